// File: doc/BRIEF.md
# Indirect Configuration Register Bridge

This block lets a host bus reach a large internal configuration space, and the management (MDIO) interface behind it, through four direct registers. To write, the host places a value in the low-word register and then writes the control register with the write bit set, a core-select bit and a 10-bit internal address. To read, the host writes the control register with the write bit clear and collects the result from the low-word register. A ready register carries one completion flag per access type. Each flag drops when an access of its type is accepted and rises again when that access finishes.

Configuration accesses complete a fixed `CFG_LAT` clock edges after the control write is accepted. Each of the two cores has its own bank of internal registers. One internal address holds the MDIO write data. An access to a second internal address is handed to an external MDIO master as a one-cycle request. The request stays open until that master returns `mdio_done`. Only one access is in flight at a time, and a control write that arrives while one is pending is dropped.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the ready register (offset 0x2C) reads 0x66, which means every flag is set. The low-word (0x24) and high-word (0x20) registers read 0, and `mdio_req` is low.
- R2: A host write to offset 0x20 or 0x24 is read back unchanged. Offsets outside 0x20, 0x24, 0x28 and 0x2C read as 0.
- R3: A control write (offset 0x28) with bit 15 set stores the current low word into the internal register selected by bit 10 (core) and bits 9:0 (address). Ready bit 6 is 0 right after the write and becomes 1 exactly `CFG_LAT` clock edges after the accepting edge.
- R4: A control write with bit 15 clear reads the selected internal register into the low word. Ready bit 5 clears on acceptance and sets `CFG_LAT` edges later, in the same edge that loads the low word.
- R5: The two cores have separate storage. A write to core 1 does not change core 0 at the same address, and the reverse also holds.
- R6: The internal addresses 0x240, 0x280, 0x300, 0x340, 0x380, 0x384, 0x390 and 0x3B0 are storage. A read of any other address returns 0 and still sets its ready flag, and a write to such an address stores nothing.
- R7: A write access to internal address 0x3B4 raises `mdio_req` for exactly one cycle with `mdio_write`=1, `mdio_core`=bit 10, `mdio_phy`=low word bits 9:5, `mdio_reg`=low word bits 4:0, and `mdio_wdata`=bits 15:0 of that core's 0x3B0 register. Ready bit 2 clears on acceptance and sets at the edge where `mdio_done` is seen.
- R8: A read access to 0x3B4 issues the request with `mdio_write`=0 and clears ready bit 1. At the edge where `mdio_done` is seen, the low word becomes `mdio_rdata` zero-extended and bit 1 sets.
- R9: A control write accepted while an access is pending is ignored. It causes no new request, no store and no change of ready flags.
- R10: `mdio_done` has no effect when no MDIO access is pending.
- R11: The ready register is read-only, and host writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 6 | Host byte offset within the window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for `bus_addr` (combinational) |
| mdio_req | output | 1 | One-cycle start of an MDIO transaction |
| mdio_write | output | 1 | 1 = MDIO write, 0 = MDIO read |
| mdio_core | output | 1 | Core that issued the MDIO transaction |
| mdio_phy | output | 5 | PHY address |
| mdio_reg | output | 5 | PHY register number |
| mdio_wdata | output | 16 | MDIO write data |
| mdio_done | input | 1 | MDIO master finished the transaction |
| mdio_rdata | input | 16 | MDIO read result, valid with `mdio_done` |

## Verification
The bench builds the bridge with `CFG_LAT` set to 3 instead of the default 4. The three-edge window still leaves two idle cycles between acceptance and completion, and a cycle count of the ready polling loop can tell those apart from the completion edge. The MDIO master is played by the bench, which can hold `mdio_done` back for as long as it needs. That makes room to fire a second control write into the pending window and to pulse `mdio_done` while nothing is pending.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int DW      = 32;
  localparam int AW      = 6;
  localparam int IADDR_W = 10;
  localparam int MD_DW   = 16;
  localparam int NSLOT   = 8;
  localparam int SLOT_W  = $clog2(NSLOT);

  // host window offsets
  localparam logic [AW-1:0] OFF_HIGH = 6'h20;
  localparam logic [AW-1:0] OFF_LOW  = 6'h24;
  localparam logic [AW-1:0] OFF_CTRL = 6'h28;
  localparam logic [AW-1:0] OFF_RDY  = 6'h2C;

  // control word field positions
  localparam int CTL_WR_BIT   = 15;
  localparam int CTL_CORE_BIT = 10;

  // internal addresses
  localparam logic [IADDR_W-1:0] IA_RX_CFG  = 10'h240;
  localparam logic [IADDR_W-1:0] IA_TX_CFG  = 10'h280;
  localparam logic [IADDR_W-1:0] IA_SPEED   = 10'h300;
  localparam logic [IADDR_W-1:0] IA_MGMT    = 10'h340;
  localparam logic [IADDR_W-1:0] IA_STA_LO  = 10'h380;
  localparam logic [IADDR_W-1:0] IA_STA_HI  = 10'h384;
  localparam logic [IADDR_W-1:0] IA_FILTER  = 10'h390;
  localparam logic [IADDR_W-1:0] IA_MD_WDAT = 10'h3B0;
  localparam logic [IADDR_W-1:0] IA_MD_GO   = 10'h3B4;

  localparam logic [SLOT_W-1:0] MD_WDAT_SLOT = 3'd7;

  // access kind = {is_mdio, is_write}; doubles as ready-flag index
  typedef enum logic [1:0] {
    ACC_CFG_RD = 2'b00,
    ACC_CFG_WR = 2'b01,
    ACC_MD_RD  = 2'b10,
    ACC_MD_WR  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic               wr;
    logic               core;
    logic [IADDR_W-1:0] addr;
  } ctrl_fields_t;

  function automatic ctrl_fields_t split_ctrl(input logic [DW-1:0] w);
    ctrl_fields_t f;
    f.wr   = w[CTL_WR_BIT];
    f.core = w[CTL_CORE_BIT];
    f.addr = w[IADDR_W-1:0];
    return f;
  endfunction

  // {hit, slot index}
  function automatic logic [SLOT_W:0] slot_of(input logic [IADDR_W-1:0] a);
    logic [SLOT_W:0] r;
    case (a)
      IA_RX_CFG:  r = {1'b1, 3'd0};
      IA_TX_CFG:  r = {1'b1, 3'd1};
      IA_SPEED:   r = {1'b1, 3'd2};
      IA_MGMT:    r = {1'b1, 3'd3};
      IA_STA_LO:  r = {1'b1, 3'd4};
      IA_STA_HI:  r = {1'b1, 3'd5};
      IA_FILTER:  r = {1'b1, 3'd6};
      IA_MD_WDAT: r = {1'b1, MD_WDAT_SLOT};
      default:    r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [1:0] kind_of(input ctrl_fields_t f);
    return {f.addr == IA_MD_GO, f.wr};
  endfunction

  // flag vector index = acc_kind_e; bit positions in the host-visible word
  function automatic logic [DW-1:0] ready_word(input logic [3:0] rdy);
    logic [DW-1:0] w;
    w    = '0;
    w[5] = rdy[ACC_CFG_RD];
    w[6] = rdy[ACC_CFG_WR];
    w[1] = rdy[ACC_MD_RD];
    w[2] = rdy[ACC_MD_WR];
    return w;
  endfunction

endpackage

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile
  import cfgwin_pkg::*;
#(
  parameter int NCORES = 2,
  parameter int REG_W  = DW,
  localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CORE_W-1:0]  wr_core,
  input  logic [IADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [CORE_W-1:0]  rd_core,
  input  logic [IADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]   rd_data,
  input  logic [CORE_W-1:0]  md_core,
  output logic [MD_DW-1:0]   md_wdata
);

  logic [SLOT_W:0] wr_slot, rd_slot;
  logic            wr_hit, rd_hit;

  assign wr_slot = slot_of(wr_addr);
  assign rd_slot = slot_of(rd_addr);
  assign wr_hit  = wr_slot[SLOT_W];
  assign rd_hit  = rd_slot[SLOT_W];

  logic [REG_W-1:0] core_rd [NCORES];
  logic [MD_DW-1:0] core_md [NCORES];

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic [REG_W-1:0] bank [NSLOT];
    logic             sel_wr;

    assign sel_wr = we && wr_hit && (wr_core == CORE_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < NSLOT; s++) bank[s] <= '0;
      end else if (sel_wr) begin
        bank[wr_slot[SLOT_W-1:0]] <= wr_data;
      end
    end

    assign core_rd[c] = rd_hit ? bank[rd_slot[SLOT_W-1:0]] : '0;
    assign core_md[c] = bank[MD_WDAT_SLOT][MD_DW-1:0];
  end

  assign rd_data  = core_rd[rd_core];
  assign md_wdata = core_md[md_core];

endmodule

// File: rtl/cfgwin_host_regs.sv
module cfgwin_host_regs
  import cfgwin_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_val,
  input  logic [3:0]    rdy,
  output logic [DW-1:0] low_word,
  output logic          ctrl_wr_evt,
  output logic [DW-1:0] ctrl_word
);

  logic [DW-1:0] hi_q, lo_q, ctrl_q;

  assign ctrl_wr_evt = bus_we && (bus_addr == OFF_CTRL);
  assign ctrl_word   = bus_wdata;
  assign low_word    = lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (bus_we && bus_addr == OFF_HIGH) hi_q <= bus_wdata;
      if (ctrl_wr_evt) ctrl_q <= bus_wdata;
      // completion of a read wins over a host write in the same cycle
      if (ld_en) lo_q <= ld_val;
      else if (bus_we && bus_addr == OFF_LOW) lo_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_HIGH: bus_rdata = hi_q;
      OFF_LOW:  bus_rdata = lo_q;
      OFF_CTRL: bus_rdata = ctrl_q;
      OFF_RDY:  bus_rdata = ready_word(rdy);
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
  import cfgwin_pkg::*;
#(
  parameter int CFG_LAT = 4,
  localparam int CNT_W  = (CFG_LAT > 1) ? $clog2(CFG_LAT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr_evt,
  input  logic [DW-1:0]      ctrl_word,
  input  logic [DW-1:0]      low_word,
  input  logic [DW-1:0]      rf_rdata,
  input  logic [MD_DW-1:0]   md_wd_in,
  output logic               md_sel_core,
  output logic               rf_we,
  output logic               rf_core,
  output logic [IADDR_W-1:0] rf_addr,
  output logic [DW-1:0]      rf_wdata,
  output logic               ld_en,
  output logic [DW-1:0]      ld_val,
  output logic [3:0]         rdy,
  output logic               busy,
  output logic               accept,
  output logic [1:0]         in_kind,
  output logic               done_evt,
  output logic               mdio_pend,
  input  logic               mdio_done,
  input  logic [MD_DW-1:0]   mdio_rdata,
  output logic               mdio_req,
  output logic               mdio_write,
  output logic               mdio_core,
  output logic [4:0]         mdio_phy,
  output logic [4:0]         mdio_reg,
  output logic [MD_DW-1:0]   mdio_wdata
);

  ctrl_fields_t       f;
  logic               is_md, op_wr, op_core;
  logic [IADDR_W-1:0] op_addr;
  logic [DW-1:0]      op_data;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         op_kind;

  assign f           = split_ctrl(ctrl_word);
  assign in_kind     = kind_of(f);
  assign md_sel_core = f.core;
  assign accept      = ctrl_wr_evt && !busy;
  assign op_kind     = {is_md, op_wr};
  assign mdio_pend   = busy && is_md;
  assign done_evt    = busy && (is_md ? mdio_done : (cnt == '0));

  assign rf_we    = done_evt && !is_md && op_wr;
  assign rf_core  = op_core;
  assign rf_addr  = op_addr;
  assign rf_wdata = op_data;
  assign ld_en    = done_evt && !op_wr;
  assign ld_val   = is_md ? {{(DW-MD_DW){1'b0}}, mdio_rdata} : rf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      is_md      <= 1'b0;
      op_wr      <= 1'b0;
      op_core    <= 1'b0;
      op_addr    <= '0;
      op_data    <= '0;
      cnt        <= '0;
      rdy        <= 4'b1111;
      mdio_req   <= 1'b0;
      mdio_write <= 1'b0;
      mdio_core  <= 1'b0;
      mdio_phy   <= '0;
      mdio_reg   <= '0;
      mdio_wdata <= '0;
    end else begin
      mdio_req <= 1'b0;
      if (accept) begin
        busy          <= 1'b1;
        op_wr         <= f.wr;
        op_core       <= f.core;
        op_addr       <= f.addr;
        op_data       <= low_word;
        cnt           <= CNT_W'(CFG_LAT - 1);
        is_md         <= in_kind[1];
        rdy[in_kind]  <= 1'b0;
        if (in_kind[1]) begin
          mdio_req   <= 1'b1;
          mdio_write <= f.wr;
          mdio_core  <= f.core;
          mdio_phy   <= low_word[9:5];
          mdio_reg   <= low_word[4:0];
          mdio_wdata <= md_wd_in;
        end
      end else if (done_evt) begin
        busy         <= 1'b0;
        is_md        <= 1'b0;
        rdy[op_kind] <= 1'b1;
      end else if (busy && !is_md) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfgwin_pkg::*;
#(
  parameter int CFG_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [5:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          mdio_req,
  output logic          mdio_write,
  output logic          mdio_core,
  output logic [4:0]    mdio_phy,
  output logic [4:0]    mdio_reg,
  output logic [15:0]   mdio_wdata,
  input  logic          mdio_done,
  input  logic [15:0]   mdio_rdata
);

  // named internal events, observed by the bound checker
  logic               ctrl_wr_evt, accept_w, done_w, busy_w, mdio_pend_w;
  logic [1:0]         issue_kind;
  logic [3:0]         rdy_flags;
  logic [DW-1:0]      ctrl_word, low_word, ld_val, rf_rdata, rf_wdata;
  logic               ld_en, rf_we, rf_core, md_sel_core;
  logic [IADDR_W-1:0] rf_addr;
  logic [MD_DW-1:0]   md_wd;

  cfgwin_host_regs u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ld_en       (ld_en),
    .ld_val      (ld_val),
    .rdy         (rdy_flags),
    .low_word    (low_word),
    .ctrl_wr_evt (ctrl_wr_evt),
    .ctrl_word   (ctrl_word)
  );

  cfgwin_seq #(.CFG_LAT(CFG_LAT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr_evt (ctrl_wr_evt),
    .ctrl_word   (ctrl_word),
    .low_word    (low_word),
    .rf_rdata    (rf_rdata),
    .md_wd_in    (md_wd),
    .md_sel_core (md_sel_core),
    .rf_we       (rf_we),
    .rf_core     (rf_core),
    .rf_addr     (rf_addr),
    .rf_wdata    (rf_wdata),
    .ld_en       (ld_en),
    .ld_val      (ld_val),
    .rdy         (rdy_flags),
    .busy        (busy_w),
    .accept      (accept_w),
    .in_kind     (issue_kind),
    .done_evt    (done_w),
    .mdio_pend   (mdio_pend_w),
    .mdio_done   (mdio_done),
    .mdio_rdata  (mdio_rdata),
    .mdio_req    (mdio_req),
    .mdio_write  (mdio_write),
    .mdio_core   (mdio_core),
    .mdio_phy    (mdio_phy),
    .mdio_reg    (mdio_reg),
    .mdio_wdata  (mdio_wdata)
  );

  cfgwin_regfile #(.NCORES(2), .REG_W(DW)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (rf_we),
    .wr_core  (rf_core),
    .wr_addr  (rf_addr),
    .wr_data  (rf_wdata),
    .rd_core  (rf_core),
    .rd_addr  (rf_addr),
    .rd_data  (rf_rdata),
    .md_core  (md_sel_core),
    .md_wdata (md_wd)
  );

endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker #(
  parameter int CFG_LAT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic [1:0] kind,
  input logic       done_evt,
  input logic       busy,
  input logic       mdio_pend,
  input logic       mdio_done,
  input logic [3:0] rdy,
  input logic       mdio_req,
  input logic [4:0] mdio_phy,
  input logic [4:0] mdio_reg
);

  // cycles since a configuration access was accepted
  logic        track;
  logic [15:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track <= 1'b0;
      since <= '0;
    end else if (accept && !kind[1]) begin
      track <= 1'b1;
      since <= 16'd1;
    end else if (track) begin
      if (done_evt) track <= 1'b0;
      else since <= since + 16'd1;
    end
  end

  p_cfg_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (track && since == 16'(CFG_LAT)) |-> done_evt);

  p_cfg_not_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (track && since < 16'(CFG_LAT)) |-> !done_evt);

  p_issue_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == 2'b01) |=> !rdy[1]);

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |=> !mdio_req);

  p_md_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == 2'b10) |=> (mdio_req && !rdy[2]));

  p_md_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_pend && !mdio_done) |=> ($stable(mdio_phy) && $stable(mdio_reg)));

  p_ready_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt) |=> $stable(rdy));

  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_done && !mdio_pend && !accept) |=> $stable(rdy[3:2]));

endmodule

bind cfg_window_bridge cfgwin_checker #(.CFG_LAT(CFG_LAT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept_w),
  .kind      (issue_kind),
  .done_evt  (done_w),
  .busy      (busy_w),
  .mdio_pend (mdio_pend_w),
  .mdio_done (mdio_done),
  .rdy       (rdy_flags),
  .mdio_req  (mdio_req),
  .mdio_phy  (mdio_phy),
  .mdio_reg  (mdio_reg)
);

// File: tb/cfg_window_bridge_tb_top.sv
module cfg_window_bridge_tb_top;

  localparam int LAT = 3;
  localparam logic [5:0] A_HIGH = 6'h20, A_LOW = 6'h24, A_CTRL = 6'h28, A_RDY = 6'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdio_req, mdio_write, mdio_core;
  logic [4:0]  mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata;
  logic        mdio_done = 1'b0;
  logic [15:0] mdio_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfg_window_bridge #(.CFG_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdio_req(mdio_req),
    .mdio_write(mdio_write), .mdio_core(mdio_core), .mdio_phy(mdio_phy),
    .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_done(mdio_done),
    .mdio_rdata(mdio_rdata)
  );

  typedef struct packed {
    logic        core;
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'h240, 32'h1111_0001, 32'h1111_0001},
    '{1'b0, 10'h280, 32'h2222_0002, 32'h2222_0002},
    '{1'b0, 10'h300, 32'h8000_0000, 32'h8000_0000},
    '{1'b1, 10'h300, 32'h4000_0000, 32'h4000_0000},
    '{1'b0, 10'h380, 32'h0302_0100, 32'h0302_0100},
    '{1'b1, 10'h384, 32'h0000_0504, 32'h0000_0504},
    '{1'b0, 10'h390, 32'h8000_0000, 32'h8000_0000},
    '{1'b0, 10'h3C0, 32'hDEAD_BEEF, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input logic wr, input logic core, input logic [9:0] a);
    return {16'h0, wr, 4'h0, core, a};
  endfunction

  task automatic wait_ready(input int bitpos, output int cyc);
    logic [31:0] r;
    cyc = 0;
    bus_read(A_RDY, r);
    while (r[bitpos] == 1'b0 && cyc < 200) begin
      @(negedge clk);
      cyc++;
      bus_read(A_RDY, r);
    end
  endtask

  task automatic cfg_write(input logic core, input logic [9:0] a, input logic [31:0] d, output int lat);
    bus_write(A_LOW, d);
    bus_write(A_CTRL, ctl(1'b1, core, a));
    wait_ready(6, lat);
  endtask

  task automatic cfg_read(input logic core, input logic [9:0] a, output logic [31:0] d, output int lat);
    bus_write(A_CTRL, ctl(1'b0, core, a));
    wait_ready(5, lat);
    bus_read(A_LOW, d);
  endtask

  task automatic pulse_done(input logic [15:0] rd);
    @(negedge clk);
    mdio_done = 1'b1; mdio_rdata = rd;
    @(negedge clk);
    mdio_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int lat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_RDY, r);  check("R1 ready", r, 32'h66);
    bus_read(A_LOW, r);  check("R1 low", r, 32'h0);
    bus_read(A_HIGH, r); check("R1 high", r, 32'h0);
    check("R1 mdio_req", {31'b0, mdio_req}, 32'h0);

    // R2 direct registers
    bus_write(A_HIGH, 32'hCAFE_F00D);
    bus_read(A_HIGH, r); check("R2 high", r, 32'hCAFE_F00D);
    bus_write(A_LOW, 32'h1357_9BDF);
    bus_read(A_LOW, r);  check("R2 low", r, 32'h1357_9BDF);
    bus_read(6'h30, r);  check("R2 unmapped offset", r, 32'h0);

    // R3 ready clears on issue, latency
    bus_write(A_LOW, 32'h0000_00AA);
    bus_write(A_CTRL, ctl(1'b1, 1'b0, 10'h340));
    bus_read(A_RDY, r);  check("R3 bit6 cleared", {31'b0, r[6]}, 32'h0);
    wait_ready(6, lat);  check("R3 write latency", lat, LAT);

    // table: write all, then read all back (R3 store, R4 read, R5, R6)
    for (int i = 0; i < NV; i++) cfg_write(VEC[i].core, VEC[i].addr, VEC[i].wdata, lat);
    for (int i = 0; i < NV; i++) begin
      cfg_read(VEC[i].core, VEC[i].addr, r, lat);
      check($sformatf("R4 readback %0d", i), r, VEC[i].expv);
    end

    // R4 read latency and data
    cfg_read(1'b0, 10'h340, r, lat);
    check("R4 read latency", lat, LAT);
    check("R4 read data", r, 32'h0000_00AA);

    // R5 core separation
    cfg_read(1'b1, 10'h240, r, lat); check("R5 core1 untouched", r, 32'h0);
    cfg_read(1'b0, 10'h384, r, lat); check("R5 core0 untouched", r, 32'h0);

    // R6 unmapped read still completes
    bus_write(A_LOW, 32'hFFFF_FFFF);
    cfg_read(1'b1, 10'h004, r, lat);
    check("R6 unmapped data", r, 32'h0);
    check("R6 unmapped latency", lat, LAT);

    // R7 MDIO write
    cfg_write(1'b1, 10'h3B0, 32'h0000_5A5A, lat);
    bus_write(A_LOW, {22'h0, 5'd7, 5'd19});
    bus_write(A_CTRL, ctl(1'b1, 1'b1, 10'h3B4));
    check("R7 req", {31'b0, mdio_req}, 32'h1);
    check("R7 write", {31'b0, mdio_write}, 32'h1);
    check("R7 core", {31'b0, mdio_core}, 32'h1);
    check("R7 phy", {27'b0, mdio_phy}, 32'd7);
    check("R7 reg", {27'b0, mdio_reg}, 32'd19);
    check("R7 wdata", {16'b0, mdio_wdata}, 32'h5A5A);
    bus_read(A_RDY, r); check("R7 bit2 cleared", {31'b0, r[2]}, 32'h0);
    @(negedge clk);
    check("R7 req one cycle", {31'b0, mdio_req}, 32'h0);

    // R9 control write during pending MDIO access is dropped
    bus_write(A_CTRL, ctl(1'b1, 1'b0, 10'h240));
    check("R9 no new req", {31'b0, mdio_req}, 32'h0);
    bus_read(A_RDY, r); check("R9 ready unchanged", r, 32'h62);

    pulse_done(16'h0000);
    bus_read(A_RDY, r); check("R7 bit2 set on done", r, 32'h66);
    cfg_read(1'b0, 10'h240, r, lat); check("R9 no store", r, 32'h1111_0001);

    // R8 MDIO read
    bus_write(A_LOW, {22'h0, 5'd3, 5'd2});
    bus_write(A_CTRL, ctl(1'b0, 1'b0, 10'h3B4));
    check("R8 req", {31'b0, mdio_req}, 32'h1);
    check("R8 read dir", {31'b0, mdio_write}, 32'h0);
    check("R8 phy/reg", {27'b0, mdio_phy, mdio_reg}, {22'b0, 5'd3, 5'd2});
    bus_read(A_RDY, r); check("R8 bit1 cleared", {31'b0, r[1]}, 32'h0);
    repeat (4) @(negedge clk);
    bus_read(A_RDY, r); check("R8 still pending", {31'b0, r[1]}, 32'h0);
    pulse_done(16'h1234);
    bus_read(A_LOW, r); check("R8 low word", r, 32'h0000_1234);
    bus_read(A_RDY, r); check("R8 bit1 set", r, 32'h66);

    // R10 stray done
    pulse_done(16'hBEEF);
    bus_read(A_LOW, r); check("R10 low unchanged", r, 32'h0000_1234);
    bus_read(A_RDY, r); check("R10 ready unchanged", r, 32'h66);

    // R11 ready register is read-only
    bus_write(A_RDY, 32'h0);
    bus_read(A_RDY, r); check("R11 ready read-only", r, 32'h66);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule